// File: doc/BRIEF.md
# Serial ADC Command Slave

This block is the digital face of a multi-channel serial converter on a four-wire port. A host lowers the active-low chip select, clocks a 16-bit command in on the serial data input, and at the same time receives a 16-bit word on the serial data output. The top nibble of the command picks the operation: start a conversion on a channel, start a conversion through a FIFO read, write the configuration register, or ask for the configuration register in the next frame. The four input pins are brought into the system clock domain through a synchronizer, and all edges are detected on the synchronized copies.

A conversion runs for a fixed number of system clock cycles and then captures its result from a parallel test input. No analog path is modelled. The stored result goes out on the next frame, MSB first and left-justified. One configuration bit selects how the status pin behaves. In end-of-conversion mode it marks the busy window. In interrupt mode it marks completion until the host starts a new frame. A frame that begins while a conversion is still running throws that conversion away. The frame-sync input must be high for a frame's command to count.

Top module: `adc_cmd_slave`

## Requirements
- R1: After reset the status pin `eoc_int` is high, `sdo_oe` and `sdo` are low, the stored result is zero and the configuration is zero, so the block is in end-of-conversion mode.
- R2: `sdo_oe` is high only while a frame is open, and low once chip select is high. While it is low `sdo` is low. Once chip select falls, `sdo` holds bit 15 of the outgoing word. Each rising serial clock edge moves it to the next lower bit.
- R3: A normal outgoing word is the last stored 12-bit result in bits 15:4, with zeros in bits 3:0.
- R4: A command whose bits 15:12 are 0x0 to 0x8 (channel select) or 0xE (FIFO read) starts a conversion when the 16th falling serial clock edge is seen. The conversion lasts CONV_CYCLES system clock cycles, and at its end `test_result` is stored as the new result.
- R5: In end-of-conversion mode (configuration bit 0 clear), `eoc_int` goes low when a conversion starts and returns high when it completes.
- R6: In interrupt mode (configuration bit 0 set), `eoc_int` stays high during a conversion and goes low when it completes. It then stays low until the next falling edge of chip select, which sets it high again.
- R7: Command nibble 0xA stores bits 11:0 of the command as the configuration. Nibble 0x9 starts no conversion and makes the next frame send the configuration in bits 11:0, with zeros in bits 15:12.
- R8: Command nibbles 0xB, 0xC, 0xD and 0xF start no conversion and leave the result and the configuration unchanged.
- R9: If chip select falls while a conversion is running, that conversion ends, its result is never stored, and in end-of-conversion mode `eoc_int` returns high.
- R10: If `fs` is low when chip select falls, the command clocked in during that frame is ignored. The outgoing word is still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command bit, captured on the rising serial clock edge |
| fs | input | 1 | Frame sync; held high for host-processor use |
| test_result | input | RES_W | Parallel conversion value, stored when a conversion completes |
| sdo | output | 1 | Serial output bit, MSB first |
| sdo_oe | output | 1 | Output enable for sdo; low means high-impedance |
| eoc_int | output | 1 | End-of-conversion or interrupt status pin |

## Verification
The checker watches several things on every cycle. It holds the status pin against the busy state in each mode. It checks that the output bit stays quiet while the driver is off and that the timer stays inside its window. It checks that the result register changes only in the cycle a conversion completes, and that the configuration changes only after a decoded command. It also checks that a chip select falling mid-conversion leaves the result untouched. Only the bench scenarios can show what the host actually sees: the bit order and justification of the returned word, which frame returns the configuration, that reserved and frame-sync-gated commands start nothing, and that a lost conversion leaves the old value to be read later.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

    localparam int unsigned OPC_W       = 4;
    localparam int unsigned CFG_INT_BIT = 0;

    localparam logic [OPC_W-1:0] OPC_CHAN_MAX = 4'h8;
    localparam logic [OPC_W-1:0] OPC_CFG_RD   = 4'h9;
    localparam logic [OPC_W-1:0] OPC_CFG_WR   = 4'hA;
    localparam logic [OPC_W-1:0] OPC_FIFO_RD  = 4'hE;

    function automatic logic starts_conv(input logic [OPC_W-1:0] nib);
        return (nib <= OPC_CHAN_MAX) || (nib == OPC_FIFO_RD);
    endfunction

endpackage

// File: rtl/adc_if_sync.sv
module adc_if_sync #(
    parameter int unsigned    W       = 4,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_if_frame.sv
module adc_if_frame #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              fs_s,
    input  logic [WORD_W-1:0] load_word,
    output logic              cs_fall,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_word,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              cs_prev;
        logic              sclk_prev;
        logic              active;
        logic              fs_ok;
        logic              done;
        logic              cmd_valid;
        logic [CNT_W-1:0]  rcnt;
        logic [WORD_W-1:0] shin;
        logic [WORD_W-1:0] shout;
    } frm_t;

    frm_t frm_d, frm_q;
    logic sclk_rise, sclk_fall;

    always_comb begin
        frm_d           = frm_q;
        frm_d.cmd_valid = 1'b0;
        frm_d.cs_prev   = cs_n_s;
        frm_d.sclk_prev = sclk_s;

        cs_fall   = frm_q.cs_prev & ~cs_n_s;
        sclk_rise = ~frm_q.sclk_prev & sclk_s;
        sclk_fall = frm_q.sclk_prev & ~sclk_s;

        if (cs_fall) begin
            frm_d.active = 1'b1;
            frm_d.rcnt   = '0;
            frm_d.shout  = load_word;
            frm_d.fs_ok  = fs_s;
            frm_d.done   = 1'b0;
        end else if (cs_n_s) begin
            frm_d.active = 1'b0;
        end else if (frm_q.active) begin
            if (sclk_rise && (frm_q.rcnt < CNT_W'(WORD_W))) begin
                frm_d.shin  = {frm_q.shin[WORD_W-2:0], sdi_s};
                frm_d.shout = {frm_q.shout[WORD_W-2:0], 1'b0};
                frm_d.rcnt  = frm_q.rcnt + 1'b1;
            end
            if (sclk_fall && (frm_q.rcnt == CNT_W'(WORD_W)) && !frm_q.done) begin
                frm_d.done      = 1'b1;
                frm_d.cmd_valid = frm_q.fs_ok;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q         <= '0;
            frm_q.cs_prev <= 1'b1;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign cmd_valid = frm_q.cmd_valid;
    assign cmd_word  = frm_q.shin;
    assign sdo       = frm_q.shout[WORD_W-1] & frm_q.active;
    assign sdo_oe    = frm_q.active;

endmodule

// File: rtl/adc_if_ctrl.sv
module adc_if_ctrl
    import adc_if_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned RES_W       = 12,
    parameter int unsigned CONV_CYCLES = 35,
    localparam int unsigned CFG_W      = WORD_W - OPC_W,
    localparam int unsigned TMR_W      = $clog2(CONV_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic [RES_W-1:0]  test_result,
    output logic [WORD_W-1:0] load_word,
    output logic              eoc_int,
    output logic              busy,
    output logic [TMR_W-1:0]  timer,
    output logic [RES_W-1:0]  result,
    output logic [CFG_W-1:0]  cfg
);

    typedef struct packed {
        logic             busy;
        logic             pin;
        logic             rdcfg;
        logic [TMR_W-1:0] timer;
        logic [CFG_W-1:0] cfg;
        logic [RES_W-1:0] result;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic             int_mode;
    logic             done_now;
    logic [OPC_W-1:0] nib;

    always_comb begin
        ctl_d    = ctl_q;
        int_mode = ctl_q.cfg[CFG_INT_BIT];
        nib      = cmd_word[WORD_W-1 -: OPC_W];
        done_now = ctl_q.busy && (ctl_q.timer == '0);

        if (ctl_q.busy) begin
            if (done_now) begin
                ctl_d.busy   = 1'b0;
                ctl_d.result = test_result;
                ctl_d.pin    = int_mode ? 1'b0 : 1'b1;
            end else begin
                ctl_d.timer = ctl_q.timer - 1'b1;
            end
        end

        if (cs_fall) begin
            ctl_d.rdcfg = 1'b0;
            if (int_mode) begin
                ctl_d.pin = 1'b1;
            end
            if (ctl_q.busy && !done_now) begin
                ctl_d.busy = 1'b0;
                ctl_d.pin  = 1'b1;
            end
        end

        if (cmd_valid) begin
            if (starts_conv(nib)) begin
                ctl_d.busy  = 1'b1;
                ctl_d.timer = TMR_W'(CONV_CYCLES - 1);
                if (!int_mode) begin
                    ctl_d.pin = 1'b0;
                end
            end else if (nib == OPC_CFG_WR) begin
                ctl_d.cfg = cmd_word[CFG_W-1:0];
                ctl_d.pin = 1'b1;
            end else if (nib == OPC_CFG_RD) begin
                ctl_d.rdcfg = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.pin <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign load_word = ctl_q.rdcfg ? {{(WORD_W-CFG_W){1'b0}}, ctl_q.cfg}
                                   : {ctl_q.result, {(WORD_W-RES_W){1'b0}}};
    assign eoc_int   = ctl_q.pin;
    assign busy      = ctl_q.busy;
    assign timer     = ctl_q.timer;
    assign result    = ctl_q.result;
    assign cfg       = ctl_q.cfg;

endmodule

// File: rtl/adc_cmd_slave.sv
module adc_cmd_slave #(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned RES_W       = 12,
    parameter int unsigned CONV_CYCLES = 35,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             fs,
    input  logic [RES_W-1:0] test_result,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             eoc_int
);

    localparam int unsigned CFG_W = WORD_W - adc_if_pkg::OPC_W;
    localparam int unsigned TMR_W = $clog2(CONV_CYCLES + 1);

    logic              cs_n_s, sclk_s, sdi_s, fs_s;
    logic              cs_fall, cmd_valid;
    logic [WORD_W-1:0] cmd_word, load_word;
    logic              conv_busy;
    logic [TMR_W-1:0]  conv_timer;
    logic [RES_W-1:0]  conv_result;
    logic [CFG_W-1:0]  cfg_word;

    adc_if_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1000)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi, fs}),
        .q     ({cs_n_s, sclk_s, sdi_s, fs_s})
    );

    adc_if_frame #(
        .WORD_W (WORD_W)
    ) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .sdi_s     (sdi_s),
        .fs_s      (fs_s),
        .load_word (load_word),
        .cs_fall   (cs_fall),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    adc_if_ctrl #(
        .WORD_W      (WORD_W),
        .RES_W       (RES_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall     (cs_fall),
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word),
        .test_result (test_result),
        .load_word   (load_word),
        .eoc_int     (eoc_int),
        .busy        (conv_busy),
        .timer       (conv_timer),
        .result      (conv_result),
        .cfg         (cfg_word)
    );

endmodule

// File: rtl/adc_cmd_slave_chk.sv
module adc_cmd_slave_chk #(
    parameter int unsigned RES_W       = 12,
    parameter int unsigned CFG_W       = 12,
    parameter int unsigned TMR_W       = 6,
    parameter int unsigned CONV_CYCLES = 35
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             eoc_int,
    input logic             cs_fall,
    input logic             cmd_valid,
    input logic             conv_busy,
    input logic [TMR_W-1:0] conv_timer,
    input logic [RES_W-1:0] conv_result,
    input logic [CFG_W-1:0] cfg_word
);

    logic int_mode;
    assign int_mode = cfg_word[adc_if_pkg::CFG_INT_BIT];

    // R2: no data bit leaks while the driver is off
    p_oe_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    // R4: the timer never leaves its window while busy
    p_timer_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> (conv_timer <= TMR_W'(CONV_CYCLES - 1)));

    // R4: the result moves only at a completing cycle
    p_result_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_busy && (conv_timer == '0)) |=> $stable(conv_result));

    // R5: end-of-conversion mode keeps the pin high when idle
    p_eoc_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_mode && !conv_busy) |-> eoc_int);

    // R6: interrupt mode never asserts during a conversion
    p_int_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && conv_busy) |-> eoc_int);

    // R7: configuration changes only after a decoded command
    p_cfg_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(cfg_word));

    // R9: chip select mid-conversion drops it and keeps the old result
    p_abort_keeps_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && conv_busy && (conv_timer != '0)) |=> (!conv_busy && $stable(conv_result)));

endmodule

bind adc_cmd_slave adc_cmd_slave_chk #(
    .RES_W       (RES_W),
    .CFG_W       (CFG_W),
    .TMR_W       (TMR_W),
    .CONV_CYCLES (CONV_CYCLES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .eoc_int     (eoc_int),
    .cs_fall     (cs_fall),
    .cmd_valid   (cmd_valid),
    .conv_busy   (conv_busy),
    .conv_timer  (conv_timer),
    .conv_result (conv_result),
    .cfg_word    (cfg_word)
);

// File: tb/adc_cmd_slave_tb_top.sv
module adc_cmd_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HS         = 6;
    localparam int CONV       = 35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        fs = 1'b1;
    logic [11:0] test_result = '0;
    logic        sdo, sdo_oe, eoc_int;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] rx_word;
    event        frame_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_cmd_slave #(.CONV_CYCLES(CONV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .fs          (fs),
        .test_result (test_result),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .eoc_int     (eoc_int)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HS);
        check("R2 oe on in frame", {15'd0, sdo_oe}, 16'd1);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        wait_clk(HS);
    endtask

    // driver: pushes the expected word, then clocks the frame
    task automatic shift_word(input logic [15:0] cmd, input logic [15:0] exp, input string tag);
        logic [15:0] rx;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 0; i < 16; i++) begin
            sdi = cmd[15-i];
            wait_clk(HS);
            rx[15-i] = sdo;
            sclk = 1'b1;
            wait_clk(HS);
            sclk = 1'b0;
            wait_clk(HS);
        end
        rx_word = rx;
        ->frame_done;
    endtask

    task automatic frame(input logic [15:0] cmd, input logic [15:0] exp, input string tag);
        cs_low();
        shift_word(cmd, exp, tag);
        cs_high();
    endtask

    // monitor: pops one expected word for each completed frame
    initial begin
        forever begin
            @(frame_done);
            if (exp_q.size() == 0) begin
                check("monitor queue empty", rx_word, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), rx_word, exp_q.pop_front());
            end
        end
    end

    initial begin
        wait_clk(100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // R1 reset state
        check("R1 eoc_int reset", {15'd0, eoc_int}, 16'd1);
        check("R1 sdo_oe reset", {15'd0, sdo_oe}, 16'd0);
        check("R1 sdo reset", {15'd0, sdo}, 16'd0);

        // R4 R5 channel 0 conversion; first frame returns the reset result
        test_result = 12'hABC;
        frame(16'h0000, 16'h0000, "R1 reset result");
        wait_clk(2);
        check("R2 oe off after frame", {15'd0, sdo_oe}, 16'd0);
        check("R5 eoc low in conversion", {15'd0, eoc_int}, 16'd0);
        wait_clk(CONV + 15);
        check("R5 eoc high after conversion", {15'd0, eoc_int}, 16'd1);

        // R8 reserved nibble B; R3 left-justified result
        frame(16'hB000, 16'hABC0, "R3 left-justified result");
        wait_clk(2);
        check("R8 reserved starts nothing", {15'd0, eoc_int}, 16'd1);

        // R4 FIFO read starts a conversion
        test_result = 12'h123;
        frame(16'hE000, 16'hABC0, "R4 fifo read frame data");
        wait_clk(2);
        check("R4 fifo read converts", {15'd0, eoc_int}, 16'd0);
        wait_clk(CONV + 15);

        // R9 abort: new chip select during conversion
        test_result = 12'h5A5;
        frame(16'h3000, 16'h1230, "R4 fifo result stored");
        wait_clk(2);
        cs_low();
        shift_word(16'hC000, 16'h1230, "R9 abort frame data");
        cs_high();
        wait_clk(2);
        check("R9 eoc high after abort", {15'd0, eoc_int}, 16'd1);
        wait_clk(CONV + 15);
        frame(16'hB000, 16'h1230, "R9 aborted result discarded");

        // R10 frame sync low ignores the command
        fs = 1'b0;
        frame(16'h1000, 16'h1230, "R10 data still sent");
        wait_clk(2);
        check("R10 no conversion with fs low", {15'd0, eoc_int}, 16'd1);
        fs = 1'b1;
        wait_clk(CONV + 15);
        frame(16'hB000, 16'h1230, "R10 result unchanged");

        // R7 configuration write then read back; bit 0 selects interrupt mode
        frame(16'hA001, 16'h1230, "R7 write frame data");
        frame(16'h9000, 16'h1230, "R7 read request frame data");
        frame(16'hB000, 16'h0001, "R7 configuration returned");

        // R6 interrupt mode
        test_result = 12'h777;
        frame(16'h2000, 16'h1230, "R6 frame data");
        wait_clk(2);
        check("R6 pin high during conversion", {15'd0, eoc_int}, 16'd1);
        wait_clk(CONV + 15);
        check("R6 interrupt asserted", {15'd0, eoc_int}, 16'd0);
        wait_clk(20);
        check("R6 interrupt held", {15'd0, eoc_int}, 16'd0);
        cs_low();
        check("R6 interrupt cleared by chip select", {15'd0, eoc_int}, 16'd1);
        shift_word(16'hB000, 16'h7770, "R3 new result after interrupt");
        cs_high();

        wait_clk(10);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule